// File: doc/BRIEF.md
# Unified Carry-Save Montgomery Multiply/Square Unit

This block performs one Montgomery modular product per operation, bit-serially, with every intermediate value kept in carry-save form. In multiply mode it forms A·B·2^-(NW+2) mod N, where A is an ordinary binary multiplicand and B arrives as a pair of carry and sum vectors. In square mode it forms B·B·2^-(NW+2) mod N from the carry-save pair alone, and the binary multiplicand is ignored. The result leaves the block as a carry vector and a sum vector. Their plain integer sum is the answer, and no carry-propagate step is taken.

A serial stage turns the carry-save multiplier into one binary bit per cycle, least significant bit first. A register then passes that bit to a row of bit slices. Each slice holds one bit of the running sum and one bit of the running carry, and it feeds them through two full-adder levels together with a partial-product bit and a modulus bit that the quotient gates. In square mode the partial product is assembled from multiplier bits that earlier cycles already produced. The bit where two parts of that product overlap is folded into a two-bit field, so the same four-operand tree serves both modes.

Because the result is below 2N and is in the same carry-save form the multiplier input takes, results can be fed straight back as the next multiplier. An exponentiation controller can chain squares and multiplies this way without converting in between.

Top module: `mont_ums`

## Requirements
- R1: After reset `done` is low and both `res_c` and `res_s` are zero.
- R2: With `op_sqr` = 0, after an operation, (`res_s` + `res_c`) mod N equals `mcand`·B·2^-(NW+2) mod N, where B = `mplr_s` + `mplr_c` and N = `modulus`.
- R3: With `op_sqr` = 1, (`res_s` + `res_c`) mod N equals B·B·2^-(NW+2) mod N, and the value on `mcand` has no effect on either result vector.
- R4: When N is odd and both `mcand` and B are below 2N, the integer `res_s` + `res_c` is below 2N.
- R5: `done` is high for exactly one cycle, NW+3 rising edges after the edge that accepts `start`.
- R6: A `start` seen while an operation is in progress is ignored: the running operation finishes on time with the operands it accepted.
- R7: From the cycle `done` is high until the next accepted `start`, `res_c` and `res_s` hold their values whatever the other inputs do.
- R8: The `res_c`/`res_s` pair of one operation may be applied unchanged as `mplr_c`/`mplr_s` of the next, so that a chain of squares and multiplies gives the Montgomery-form power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; taken only when idle |
| op_sqr | input | 1 | 0 = multiply, 1 = square; sampled with start |
| modulus | input | NW | Odd modulus N |
| mcand | input | NW+3 | Binary multiplicand A (multiply mode) |
| mplr_c | input | NW+3 | Carry vector of multiplier B |
| mplr_s | input | NW+3 | Sum vector of multiplier B |
| res_c | output | NW+3 | Carry vector of the result |
| res_s | output | NW+3 | Sum vector of the result |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
The range property takes for granted that the modulus is odd and that the multiplicand and the true sum of the two multiplier vectors are both below twice the modulus. Without that, the output bound and the exactness of the fixed-width carry-save arithmetic are not guaranteed. The stimulus forces bit 0 of every modulus high and reduces each random operand modulo 2N before splitting it into carry and sum parts. Chained runs only feed back results that are themselves below 2N.

// File: rtl/mont_ums_pkg.sv
package mont_ums_pkg;

   typedef enum logic {
      OP_MUL = 1'b0,
      OP_SQR = 1'b1
   } ums_op_e;

   // source of one square-mode pattern bit
   typedef enum logic [1:0] {
      SQ_ZERO = 2'b00,
      SQ_LOW  = 2'b01,
      SQ_CUR  = 2'b10,
      SQ_TOP  = 2'b11
   } sq_sel_e;

   function automatic logic maj3(input logic x, input logic y, input logic z);
      return (x & y) | (x & z) | (y & z);
   endfunction

   // compression steps for an NW-bit modulus (two guard bits)
   function automatic int ums_steps(input int nw);
      return nw + 2;
   endfunction

endpackage

// File: rtl/mont_cs_serial.sv
// Serial carry-save to binary stage: one multiplier bit per cycle, LSB first.
module mont_cs_serial #(
   parameter int VW = 19
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [VW-1:0] vec_c,
   input  logic [VW-1:0] vec_s,
   output logic          bit_o
);
   import mont_ums_pkg::*;

   logic [VW-1:0] c_sh;
   logic [VW-1:0] s_sh;
   logic          cin;

   generate
      if (VW < 2) begin : g_bad_vw
         $error("mont_cs_serial: VW must be at least 2");
      end
   endgenerate

   assign bit_o = c_sh[0] ^ s_sh[0] ^ cin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_sh <= '0;
         s_sh <= '0;
         cin  <= 1'b0;
      end else if (load) begin
         c_sh <= vec_c;
         s_sh <= vec_s;
         cin  <= 1'b0;
      end else if (step) begin
         c_sh <= {1'b0, c_sh[VW-1:1]};
         s_sh <= {1'b0, s_sh[VW-1:1]};
         cin  <= maj3(c_sh[0], s_sh[0], cin);
      end
   end

endmodule

// File: rtl/mont_sq_hist.sv
// Store of multiplier bits already consumed, plus the square-mode partial
// product pattern for the current step i:
//   pattern = { b[i-1], ~b[i-1], b[i-2] .. b[0], 0 }   (bits i+1 .. 0)
// whose value equals 2^i + 2*(b[i-1..0]); the overlap at bit i is folded
// into the two-bit field at the top.
module mont_sq_hist #(
   parameter int K  = 18,
   parameter int PW = K + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          adv,
   input  logic          bit_in,
   output logic [PW-1:0] pat
);
   import mont_ums_pkg::*;

   logic [K-1:0] ptr;
   logic [K-1:0] fill;
   logic [K-1:0] hist;
   logic [K+1:0] hist_x;
   logic [K:0]   ptr_e;
   logic [K:0]   ptr_x;
   logic [K:0]   fill_e;

   generate
      if (PW != K + 1) begin : g_bad_pw
         $error("mont_sq_hist: PW must equal K+1");
      end
      if (K < 3) begin : g_bad_k
         $error("mont_sq_hist: K must be at least 3");
      end
   endgenerate

   assign hist_x = {hist, 2'b00};
   assign ptr_e  = {1'b0, ptr};
   assign ptr_x  = {ptr, 1'b0};
   assign fill_e = {1'b0, fill};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr  <= K'(1);
         fill <= '0;
         hist <= '0;
      end else if (clear) begin
         ptr  <= K'(1);
         fill <= '0;
         hist <= '0;
      end else if (adv) begin
         hist <= hist | (ptr & {K{bit_in}});
         fill <= fill | ptr;
         ptr  <= ptr << 1;
      end
   end

   generate
      for (genvar j = 0; j < PW; j++) begin : g_bit
         sq_sel_e sel;
         logic    pbit;

         always_comb begin
            if (fill_e[j])      sel = SQ_LOW;
            else if (ptr_e[j])  sel = SQ_CUR;
            else if (ptr_x[j])  sel = SQ_TOP;
            else                sel = SQ_ZERO;
         end

         always_comb begin
            unique case (sel)
               SQ_LOW:  pbit = hist_x[j+1];
               SQ_CUR:  pbit = ~hist_x[j+1];
               SQ_TOP:  pbit = hist_x[j];
               default: pbit = 1'b0;
            endcase
         end

         assign pat[j] = pbit;
      end
   endgenerate

endmodule

// File: rtl/mont_pe_lsb.sv
// Reduced slice for bit 0: the modulus is odd, so the second level only
// produces a carry and its sum bit is always zero.
module mont_pe_lsb (
   input  logic s_in,
   input  logic c_in,
   input  logic pp_in,
   input  logic n0_in,
   output logic q_o,
   output logic cy1_o,
   output logic cy2_o
);
   import mont_ums_pkg::*;

   logic sum1;

   always_comb begin
      sum1  = s_in ^ c_in ^ pp_in;
      cy1_o = maj3(s_in, c_in, pp_in);
      q_o   = sum1;
      cy2_o = sum1 & n0_in;
   end

endmodule

// File: rtl/mont_pe.sv
// Full slice: two full-adder levels of the four-operand tree.
module mont_pe (
   input  logic s_in,
   input  logic c_in,
   input  logic pp_in,
   input  logic n_in,
   input  logic q_in,
   input  logic cy1_lo,
   output logic cy1_o,
   output logic sum2_o,
   output logic cy2_o
);
   import mont_ums_pkg::*;

   logic sum1;
   logic qn;

   always_comb begin
      sum1   = s_in ^ c_in ^ pp_in;
      cy1_o  = maj3(s_in, c_in, pp_in);
      qn     = q_in & n_in;
      sum2_o = sum1 ^ cy1_lo ^ qn;
      cy2_o  = maj3(sum1, cy1_lo, qn);
   end

endmodule

// File: rtl/mont_ums.sv
module mont_ums #(
   parameter int NW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             op_sqr,
   input  logic [NW-1:0]    modulus,
   input  logic [NW+2:0]    mcand,
   input  logic [NW+2:0]    mplr_c,
   input  logic [NW+2:0]    mplr_s,
   output logic [NW+2:0]    res_c,
   output logic [NW+2:0]    res_s,
   output logic             done
);
   import mont_ums_pkg::*;

   localparam int RW = NW + 3;          // register width
   localparam int K  = ums_steps(NW);   // compression steps
   localparam int CW = $clog2(K + 1);

   generate
      if (NW < 4) begin : g_bad_nw
         $error("mont_ums: NW must be at least 4");
      end
      if (RW != K + 1) begin : g_bad_rw
         $error("mont_ums: register width must be one above the step count");
      end
   endgenerate

   ums_op_e        op_q;
   logic [RW-1:0]  a_q;
   logic [NW-1:0]  n_q;
   logic [RW-1:0]  n_x;
   logic [RW-1:0]  acc_s;
   logic [RW-1:0]  acc_c;
   logic           busy;
   logic [CW-1:0]  cnt;
   logic           bpipe;
   logic           act;
   logic           accept;
   logic           ser_bit;
   logic           q;
   logic [RW-1:0]  sq_pat;
   logic [RW-1:0]  pp;
   logic [RW-1:0]  cy1;
   logic [RW-1:0]  cy2;
   logic [RW:1]    sum2;

   assign accept = start & ~busy;
   assign act    = busy & (cnt != '0);
   assign n_x    = RW'(n_q);

   mont_cs_serial #(.VW(RW)) u_ser (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .step  (busy),
      .vec_c (mplr_c),
      .vec_s (mplr_s),
      .bit_o (ser_bit)
   );

   mont_sq_hist #(.K(K), .PW(RW)) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .adv    (act),
      .bit_in (bpipe),
      .pat    (sq_pat)
   );

   // partial product, one bit per slice
   generate
      for (genvar j = 0; j < RW; j++) begin : g_pp
         assign pp[j] = bpipe & ((op_q == OP_SQR) ? sq_pat[j] : a_q[j]);
      end
   endgenerate

   // slice row: reduced slice at bit 0, full slices above, and a top
   // position whose only input is the first-level carry from below
   generate
      for (genvar j = 0; j < RW; j++) begin : g_slice
         if (j == 0) begin : g_lsb
            mont_pe_lsb u_pe (
               .s_in  (acc_s[0]),
               .c_in  (acc_c[0]),
               .pp_in (pp[0]),
               .n0_in (n_x[0]),
               .q_o   (q),
               .cy1_o (cy1[0]),
               .cy2_o (cy2[0])
            );
         end else begin : g_mid
            mont_pe u_pe (
               .s_in   (acc_s[j]),
               .c_in   (acc_c[j]),
               .pp_in  (pp[j]),
               .n_in   (n_x[j]),
               .q_in   (q),
               .cy1_lo (cy1[j-1]),
               .cy1_o  (cy1[j]),
               .sum2_o (sum2[j]),
               .cy2_o  (cy2[j])
            );
         end
      end
   endgenerate

   assign sum2[RW] = cy1[RW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q  <= OP_MUL;
         a_q   <= '0;
         n_q   <= '0;
         acc_s <= '0;
         acc_c <= '0;
         busy  <= 1'b0;
         cnt   <= '0;
         bpipe <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            op_q  <= ums_op_e'(op_sqr);
            a_q   <= mcand;
            n_q   <= modulus;
            acc_s <= '0;
            acc_c <= '0;
            busy  <= 1'b1;
            cnt   <= '0;
         end else if (busy) begin
            cnt   <= cnt + CW'(1);
            bpipe <= ser_bit;
            if (act) begin
               acc_s <= sum2[RW:1];   // sum moves one slice down
               acc_c <= cy2;          // carry stays in its slice
            end
            if (cnt == CW'(K)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign res_c = acc_c;
   assign res_s = acc_s;

endmodule

// File: rtl/mont_ums_chk.sv
module mont_ums_chk #(
   parameter int NW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          op_q,
   input logic [NW-1:0] n_q,
   input logic [NW+2:0] a_q,
   input logic [NW+2:0] res_c,
   input logic [NW+2:0] res_s
);
   localparam int RW = NW + 3;
   localparam int K  = NW + 2;
   localparam int LW = $clog2(K + 3);

   logic [LW-1:0] lat;
   logic [RW:0]   tot;
   logic [RW:0]   lim;

   assign tot = {1'b0, res_s} + {1'b0, res_c};
   assign lim = (RW + 1)'({n_q, 1'b0});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              lat <= '0;
      else if (start && !busy) lat <= '0;
      else if (busy)           lat <= lat + LW'(1);
   end

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat == LW'(K + 1)));

   // R4
   res_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (tot < lim));

   // R6
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(a_q) && $stable(n_q) && $stable(op_q)));

   // R7
   res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(res_c) && $stable(res_s)));

endmodule

bind mont_ums mont_ums_chk #(.NW(NW)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .busy  (busy),
   .done  (done),
   .op_q  (op_q),
   .n_q   (n_q),
   .a_q   (a_q),
   .res_c (res_c),
   .res_s (res_s)
);

// File: tb/mont_ums_tb.sv
module mont_ums_tb;
   localparam int NW = 16;
   localparam int RW = NW + 3;
   localparam int K  = NW + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          op_sqr = 1'b0;
   logic [NW-1:0] modulus = '0;
   logic [RW-1:0] mcand = '0;
   logic [RW-1:0] mplr_c = '0;
   logic [RW-1:0] mplr_s = '0;
   logic [RW-1:0] res_c;
   logic [RW-1:0] res_s;
   logic          done;

   int n_run  = 0;
   int n_fail = 0;
   bit ended  = 0;
   logic [31:0] rs_state = 32'h1234_5679;

   always #10 clk = ~clk;

   mont_ums #(.NW(NW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sqr(op_sqr),
      .modulus(modulus), .mcand(mcand), .mplr_c(mplr_c), .mplr_s(mplr_s),
      .res_c(res_c), .res_s(res_s), .done(done)
   );

   function automatic logic [31:0] rnd();
      rs_state = rs_state ^ (rs_state << 13);
      rs_state = rs_state ^ (rs_state >> 17);
      rs_state = rs_state ^ (rs_state << 5);
      return rs_state;
   endfunction

   function automatic longint unsigned rinv(input longint unsigned n);
      longint unsigned r = 1;
      longint unsigned h = (n + 1) / 2;
      for (int i = 0; i < K; i++) r = (r * h) % n;
      return r;
   endfunction

   function automatic longint unsigned mont(input longint unsigned a,
                                            input longint unsigned b,
                                            input longint unsigned n);
      return ((((a % n) * (b % n)) % n) * rinv(n)) % n;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint unsigned act, input longint unsigned exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one operation; returns result vectors and cycles from accepting edge to done
   task automatic do_op(input bit sq, input longint unsigned a,
                        input longint unsigned bc, input longint unsigned bs,
                        input longint unsigned n,
                        output longint unsigned rc, output longint unsigned rsum,
                        output int lat);
      @(negedge clk);
      op_sqr = sq; mcand = RW'(a); mplr_c = RW'(bc); mplr_s = RW'(bs);
      modulus = NW'(n); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      rc = res_c; rsum = res_s;
   endtask

   task automatic run_check(input string req, input bit sq,
                            input longint unsigned a, input longint unsigned b,
                            input longint unsigned pat, input longint unsigned n,
                            output longint unsigned rc, output longint unsigned rsum);
      longint unsigned bc, bs, v, e;
      int lat;
      bc = b & pat; bs = b - bc;
      do_op(sq, a, bc, bs, n, rc, rsum, lat);
      v = rc + rsum;
      e = sq ? mont(b, b, n) : mont(a, b, n);
      chk((v % n) == e, req, "congruence", v % n, e);
      chk(v < 2 * n, "R4", "below 2N", v, 2 * n);
      chk(lat == K + 1, "R5", "latency", lat, K + 1);
      @(negedge clk);
      chk(done == 1'b0, "R5", "single-cycle done", done, 0);
   endtask

   task automatic t_reset();
      chk(done == 1'b0, "R1", "done after reset", done, 0);
      chk(res_c == '0, "R1", "res_c after reset", res_c, 0);
      chk(res_s == '0, "R1", "res_s after reset", res_s, 0);
   endtask

   task automatic t_mul_random();
      longint unsigned n, a, b, rc, rsum;
      for (int t = 0; t < 6; t++) begin
         n = (longint'(rnd()) & 16'hFFFF) | 1;
         if (n < 3) n = 3;
         a = longint'(rnd()) % (2 * n);
         b = longint'(rnd()) % (2 * n);
         run_check("R2", 1'b0, a, b, longint'(rnd()), n, rc, rsum);
      end
   endtask

   task automatic t_sqr_random();
      longint unsigned n, b, rc, rsum;
      for (int t = 0; t < 6; t++) begin
         n = (longint'(rnd()) & 16'hFFFF) | 16'h8001;
         b = longint'(rnd()) % (2 * n);
         run_check("R3", 1'b1, longint'(rnd()) % (2 * n), b, longint'(rnd()), n, rc, rsum);
      end
   endtask

   task automatic t_boundary();
      longint unsigned rc, rsum, n;
      n = 65535;
      run_check("R2", 1'b0, 2 * n - 1, 2 * n - 1, 64'h5A5A5, n, rc, rsum);
      run_check("R3", 1'b1, 0, 2 * n - 1, 64'h33333, n, rc, rsum);
      run_check("R2", 1'b0, 5, 5, 2, 3, rc, rsum);
      run_check("R3", 1'b1, 0, 5, 1, 3, rc, rsum);
      run_check("R2", 1'b0, 2 * n - 1, 0, 0, n, rc, rsum);
      chk((rc + rsum) == 0, "R2", "zero multiplier gives zero", rc + rsum, 0);
   endtask

   task automatic t_sqr_ignores_a();
      longint unsigned c0, s0, c1, s1;
      run_check("R3", 1'b1, 0, 40001, 12345, 40009, c0, s0);
      run_check("R3", 1'b1, 80017, 40001, 12345, 40009, c1, s1);
      chk(c0 == c1, "R3", "res_c independent of mcand", c1, c0);
      chk(s0 == s1, "R3", "res_s independent of mcand", s1, s0);
   endtask

   task automatic t_busy_start();
      longint unsigned v, e, n;
      int lat;
      n = 50021;
      @(negedge clk);
      op_sqr = 1'b0; mcand = RW'(31337); mplr_c = RW'(1000); mplr_s = RW'(20000);
      modulus = NW'(n); start = 1'b1;
      @(negedge clk);
      start = 1'b0; lat = 0;
      repeat (5) begin @(negedge clk); lat++; end
      op_sqr = 1'b1; mcand = RW'(7); mplr_c = RW'(3); mplr_s = RW'(9);
      modulus = NW'(65521); start = 1'b1;
      @(negedge clk); lat++;
      start = 1'b0;
      while (!done && lat < 200) begin @(negedge clk); lat++; end
      v = res_c + res_s;
      e = mont(31337, 21000, n);
      chk((v % n) == e, "R6", "start during run ignored", v % n, e);
      chk(lat == K + 1, "R6", "latency kept with extra start", lat, K + 1);
   endtask

   task automatic t_hold();
      longint unsigned c0, s0;
      c0 = res_c; s0 = res_s;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         op_sqr = ~op_sqr; mcand = RW'(rnd()); mplr_c = RW'(rnd()); mplr_s = RW'(rnd());
         modulus = NW'(rnd());
      end
      @(negedge clk);
      chk(res_c == RW'(c0), "R7", "res_c held", res_c, c0);
      chk(res_s == RW'(s0), "R7", "res_s held", res_s, s0);
   endtask

   task automatic t_chain();
      longint unsigned n, m, r, am, xc, xs, rc, rsum, ex, v;
      int lat;
      bit [6:0] ebits;
      n = 61987; m = 12345; ebits = 7'b1011011;
      r = (64'd1 << K) % n;
      am = (m * r) % n;
      xc = 0; xs = r;
      ex = r;
      for (int i = 6; i >= 0; i--) begin
         do_op(1'b1, 0, xc, xs, n, rc, rsum, lat);
         xc = rc; xs = rsum;
         ex = (((ex * ex) % n) * rinv(n)) % n;
         chk(xc + xs < 2 * n, "R8", "chained square below 2N", xc + xs, 2 * n);
         if (ebits[i]) begin
            do_op(1'b0, am, xc, xs, n, rc, rsum, lat);
            xc = rc; xs = rsum;
            ex = (((ex * am) % n) * rinv(n)) % n;
         end
      end
      v = (xc + xs) % n;
      chk(v == ex, "R8", "chained power", v, ex);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mul_random();
      t_sqr_random();
      t_boundary();
      t_sqr_ignores_a();
      t_busy_start();
      t_hold();
      t_chain();
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule